// File: doc/BRIEF.md
# Serial Audio Master Clock Generator

This block drives the clock side of a serial audio port that acts as interface master. From the system clock it produces the bit clock, a frame sync and per-slot timing marks that the data shifters follow. The bit clock comes from a three-stage divider: an optional halving stage, an optional divide-by-eight stage and a programmable stage of `clk_pm + 1`. A fixed halving stage then makes the bit clock a square wave. The frame sync takes one of four shapes: I2S, left-justified, early single-bit pulse (DSP-A) or on-time single-bit pulse (DSP-B). The bit clock and the frame sync each have their own polarity inversion.

All settings are taken while `enable` is low and are held from the moment `enable` is seen high. A rejected setting raises `cfg_err` and keeps the outputs quiet until `enable` drops. When a run starts, the block spends one lead-in bit period at the last bit of the last slot. This lets the early sync shapes place their leading bit. The first frame then starts at slot 0, bit 0, and its first bit-clock high phase is full length. The sample rate is the bit-clock rate divided by the number of bits in a frame. With 32-bit slots, the bit-clock rate is the sample rate × 32 × channels.

This block has no data stream, so all pins are plain control and status with no valid/ready handshake.

Top module: `audio_clkgen`

## Requirements
- R1: The bit-clock period is 2 × (clk_half+1) × (clk_oct ? 8 : 1) × (clk_pm+1) system-clock cycles, with a 50% duty cycle. Define D as half of this period.
- R2: If the total division ratio 2 × D is below 5, the block sets `cfg_err` when `enable` is seen. Until `enable` falls it produces no bit-clock edges and no strobes. `cfg_err` clears on the cycle after `enable` is seen low. A ratio of 6 is accepted.
- R3: With I2S format (code 0), a slot count below 2 (`slots_m1` = 0) is rejected with `cfg_err`. Other formats accept a single slot.
- R4: With I2S format (code 0), the frame sync is active low. It is active in the last bit of the previous frame and in bits 0 to W−2 of slot 0, where W = `width_m1`+1.
- R5: With left-justified format (code 1), the frame sync is active high for all W bits of slot 0.
- R6: With DSP-A format (code 2), the frame sync is active high only during the last bit of the frame, one bit before slot 0.
- R7: With DSP-B format (code 3), the frame sync is active high only during bit 0 of slot 0.
- R8: `bclk_inv` inverts the bit clock and `fs_inv` inverts the frame sync. The two controls act independently, in both running and idle states.
- R9: A frame has `slots_m1`+1 slots of `width_m1`+1 bits each. `bit_idx` and `slot_idx` advance together with the bit-clock falling edge (of the uninverted clock). The frame strobe repeats every 2 × D × W × S cycles.
- R10: After `enable` is seen high, there is one arming cycle followed by one lead-in bit. The first `frame_strobe` comes 2 × D + 1 rising system-clock edges after the edge that saw `enable`. At that point the indices read slot 0, bit 0.
- R11: Changing a setting while running has no effect on the outputs until the next enable.
- R12: `slot_strobe` is a one-cycle pulse at the start of each slot. `frame_strobe` is a one-cycle pulse that coincides with the slot strobe of slot 0. Each frame has exactly S slot strobes.
- R13: While disabled, and after reset, the bit clock rests at `bclk_inv` and the frame sync rests at its inactive level XOR `fs_inv`. Both strobes stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request; settings are taken while low |
| clk_half | input | 1 | Enables the divide-by-2 pre-stage |
| clk_oct | input | 1 | Enables the divide-by-8 pre-stage |
| clk_pm | input | PM_W | Programmable stage, divides by value+1 |
| fs_format | input | 2 | 0 I2S, 1 left-justified, 2 DSP-A, 3 DSP-B |
| width_m1 | input | WB_W | Bits per slot minus one |
| slots_m1 | input | SC_W | Slots per frame minus one |
| bclk_inv | input | 1 | Inverts the bit clock |
| fs_inv | input | 1 | Inverts the frame sync |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| cfg_err | output | 1 | Settings rejected for this enable |
| slot_strobe | output | 1 | One-cycle mark at each slot start |
| frame_strobe | output | 1 | One-cycle mark at each frame start |
| slot_idx | output | SC_W | Current slot |
| bit_idx | output | WB_W | Current bit within the slot |

## Verification
The timing of every result is counted from the rising edge that first sees `enable` high:
- `cfg_err` appears on that same edge.
- The run state begins one edge later.
- The first bit-clock rise comes D edges after that.
- The first frame strobe comes D edges after the rise.

The bench drives inputs on falling system-clock edges and samples on falling edges. It therefore expects the first frame strobe on the (2D+2)-th falling edge after it raised `enable`. From then on it checks every sample:
- the frame sync against the level that the format rule gives for the `slot_idx`/`bit_idx` sampled with it;
- each bit-clock rise against the previous one, 2D apart;
- each frame strobe against the previous one, 2D·W·S apart.

The idle levels are checked two falling edges after `enable` drops.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_DSPA = 2'd2,
    FMT_DSPB = 2'd3
  } fs_fmt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2,
    ST_ERR  = 2'd3
  } gen_state_e;

  // Active level of the sync for a given shape: I2S is the only low-active one.
  function automatic logic fs_active_level(input fs_fmt_e f);
    return (f != FMT_I2S);
  endfunction

endpackage

// File: rtl/aclk_ctrl.sv
module aclk_ctrl
  import audio_clkgen_pkg::*;
#(
  parameter int PM_W      = 8,
  parameter int WB_W      = 6,
  parameter int SC_W      = 5,
  parameter int MIN_RATIO = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            in_half,
  input  logic            in_oct,
  input  logic [PM_W-1:0] in_pm,
  input  logic [1:0]      in_fmt,
  input  logic [WB_W-1:0] in_w,
  input  logic [SC_W-1:0] in_s,
  input  logic            in_binv,
  input  logic            in_finv,
  output logic            lat_half,
  output logic            lat_oct,
  output logic [PM_W-1:0] lat_pm,
  output fs_fmt_e         lat_fmt,
  output logic [WB_W-1:0] lat_w,
  output logic [SC_W-1:0] lat_s,
  output logic            lat_binv,
  output logic            lat_finv,
  output logic            run,
  output logic            cfg_err
);

  localparam int RW = PM_W + 6;

  gen_state_e     state;
  logic [RW-1:0]  ratio;
  logic           ratio_bad;
  logic           slots_bad;
  logic           cfg_bad;
  int             shamt;

  always_comb begin
    shamt     = 1 + (in_half ? 1 : 0) + (in_oct ? 3 : 0);
    ratio     = (RW'(in_pm) + RW'(1)) << shamt;
    ratio_bad = (ratio < RW'(MIN_RATIO));
    slots_bad = (fs_fmt_e'(in_fmt) == FMT_I2S) && (in_s == '0);
    cfg_bad   = ratio_bad || slots_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      lat_half <= 1'b0;
      lat_oct  <= 1'b0;
      lat_pm   <= '0;
      lat_fmt  <= FMT_I2S;
      lat_w    <= '0;
      lat_s    <= '0;
      lat_binv <= 1'b0;
      lat_finv <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          lat_half <= in_half;
          lat_oct  <= in_oct;
          lat_pm   <= in_pm;
          lat_fmt  <= fs_fmt_e'(in_fmt);
          lat_w    <= in_w;
          lat_s    <= in_s;
          lat_binv <= in_binv;
          lat_finv <= in_finv;
          if (enable) state <= cfg_bad ? ST_ERR : ST_ARM;
        end
        ST_ARM:  state <= enable ? ST_RUN : ST_IDLE;
        ST_RUN:  if (!enable) state <= ST_IDLE;
        ST_ERR:  if (!enable) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign run     = (state == ST_RUN);
  assign cfg_err = (state == ST_ERR);

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable({lat_half, lat_oct, lat_pm, lat_fmt, lat_w, lat_s, lat_binv, lat_finv})); // R11

  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && enable) |=> cfg_err); // R2

endmodule

// File: rtl/aclk_divider.sv
module aclk_divider #(
  parameter int PM_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            half,
  input  logic            oct,
  input  logic [PM_W-1:0] pm,
  output logic            bclk_raw,
  output logic            fall
);

  localparam int PRE_W = 4;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_max;
  logic [PM_W-1:0]  pm_cnt;
  logic             pre_wrap;
  logic             tick;

  always_comb begin
    unique case ({half, oct})
      2'b00:   pre_max = PRE_W'(0);
      2'b10:   pre_max = PRE_W'(1);
      2'b01:   pre_max = PRE_W'(7);
      default: pre_max = PRE_W'(15);
    endcase
  end

  assign pre_wrap = (pre_cnt == pre_max);
  assign tick     = run && pre_wrap && (pm_cnt == pm);
  assign fall     = tick && bclk_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      pm_cnt   <= '0;
      bclk_raw <= 1'b0;
    end else if (!run) begin
      pre_cnt  <= '0;
      pm_cnt   <= '0;
      bclk_raw <= 1'b0;
    end else if (pre_wrap) begin
      pre_cnt <= '0;
      if (pm_cnt == pm) begin
        pm_cnt   <= '0;
        bclk_raw <= ~bclk_raw;
      end else begin
        pm_cnt <= pm_cnt + 1'b1;
      end
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (bclk_raw != $past(bclk_raw))) |-> $past(tick)); // R1

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !bclk_raw); // R13

endmodule

// File: rtl/aclk_framer.sv
module aclk_framer #(
  parameter int WB_W = 6,
  parameter int SC_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            fall,
  input  logic [WB_W-1:0] lat_w,
  input  logic [SC_W-1:0] lat_s,
  output logic [WB_W-1:0] bit_idx,
  output logic [SC_W-1:0] slot_idx,
  output logic            slot_strobe,
  output logic            frame_strobe
);

  logic last_bit;
  logic last_slot;

  assign last_bit  = (bit_idx == lat_w);
  assign last_slot = (slot_idx == lat_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx      <= '0;
      slot_idx     <= '0;
      slot_strobe  <= 1'b0;
      frame_strobe <= 1'b0;
    end else if (!run) begin
      // Park on the last bit of the last slot: this is the lead-in bit.
      bit_idx      <= lat_w;
      slot_idx     <= lat_s;
      slot_strobe  <= 1'b0;
      frame_strobe <= 1'b0;
    end else if (fall) begin
      if (last_bit) begin
        bit_idx      <= '0;
        slot_idx     <= last_slot ? '0 : slot_idx + 1'b1;
        slot_strobe  <= 1'b1;
        frame_strobe <= last_slot;
      end else begin
        bit_idx      <= bit_idx + 1'b1;
        slot_strobe  <= 1'b0;
        frame_strobe <= 1'b0;
      end
    end else begin
      slot_strobe  <= 1'b0;
      frame_strobe <= 1'b0;
    end
  end

  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (bit_idx <= lat_w)); // R9

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (slot_idx <= lat_s)); // R9

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_strobe |=> !slot_strobe); // R12

  AST_FRAME_IN_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |-> (slot_strobe && slot_idx == '0 && bit_idx == '0)); // R12

endmodule

// File: rtl/aclk_fs_shaper.sv
module aclk_fs_shaper
  import audio_clkgen_pkg::*;
#(
  parameter int WB_W = 6,
  parameter int SC_W = 5
) (
  input  logic            run,
  input  fs_fmt_e         fmt,
  input  logic [WB_W-1:0] lat_w,
  input  logic [SC_W-1:0] lat_s,
  input  logic [WB_W-1:0] bit_idx,
  input  logic [SC_W-1:0] slot_idx,
  input  logic            finv,
  output logic            fsync
);

  logic frame_last;
  logic in_slot0;
  logic window;
  logic act;

  always_comb begin
    frame_last = (slot_idx == lat_s) && (bit_idx == lat_w);
    in_slot0   = (slot_idx == '0);
    unique case (fmt)
      FMT_I2S:  window = frame_last || (in_slot0 && (bit_idx != lat_w));
      FMT_LJ:   window = in_slot0;
      FMT_DSPA: window = frame_last;
      default:  window = in_slot0 && (bit_idx == '0);
    endcase
    act   = fs_active_level(fmt);
    fsync = ((run && window) ? act : ~act) ^ finv;
  end

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import audio_clkgen_pkg::*;
#(
  parameter int PM_W      = 8,
  parameter int WB_W      = 6,
  parameter int SC_W      = 5,
  parameter int MIN_RATIO = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            clk_half,
  input  logic            clk_oct,
  input  logic [PM_W-1:0] clk_pm,
  input  logic [1:0]      fs_format,
  input  logic [WB_W-1:0] width_m1,
  input  logic [SC_W-1:0] slots_m1,
  input  logic            bclk_inv,
  input  logic            fs_inv,
  output logic            bclk,
  output logic            fsync,
  output logic            cfg_err,
  output logic            slot_strobe,
  output logic            frame_strobe,
  output logic [SC_W-1:0] slot_idx,
  output logic [WB_W-1:0] bit_idx
);

  logic            lat_half;
  logic            lat_oct;
  logic [PM_W-1:0] lat_pm;
  fs_fmt_e         lat_fmt;
  logic [WB_W-1:0] lat_w;
  logic [SC_W-1:0] lat_s;
  logic            lat_binv;
  logic            lat_finv;
  logic            run;
  logic            bclk_raw;
  logic            fall;

  aclk_ctrl #(.PM_W(PM_W), .WB_W(WB_W), .SC_W(SC_W), .MIN_RATIO(MIN_RATIO)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .in_half  (clk_half),
    .in_oct   (clk_oct),
    .in_pm    (clk_pm),
    .in_fmt   (fs_format),
    .in_w     (width_m1),
    .in_s     (slots_m1),
    .in_binv  (bclk_inv),
    .in_finv  (fs_inv),
    .lat_half (lat_half),
    .lat_oct  (lat_oct),
    .lat_pm   (lat_pm),
    .lat_fmt  (lat_fmt),
    .lat_w    (lat_w),
    .lat_s    (lat_s),
    .lat_binv (lat_binv),
    .lat_finv (lat_finv),
    .run      (run),
    .cfg_err  (cfg_err)
  );

  aclk_divider #(.PM_W(PM_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .half     (lat_half),
    .oct      (lat_oct),
    .pm       (lat_pm),
    .bclk_raw (bclk_raw),
    .fall     (fall)
  );

  aclk_framer #(.WB_W(WB_W), .SC_W(SC_W)) u_frm (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (run),
    .fall         (fall),
    .lat_w        (lat_w),
    .lat_s        (lat_s),
    .bit_idx      (bit_idx),
    .slot_idx     (slot_idx),
    .slot_strobe  (slot_strobe),
    .frame_strobe (frame_strobe)
  );

  aclk_fs_shaper #(.WB_W(WB_W), .SC_W(SC_W)) u_fs (
    .run      (run),
    .fmt      (lat_fmt),
    .lat_w    (lat_w),
    .lat_s    (lat_s),
    .bit_idx  (bit_idx),
    .slot_idx (slot_idx),
    .finv     (lat_finv),
    .fsync    (fsync)
  );

  assign bclk = bclk_raw ^ lat_binv;

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!bclk_raw && !slot_strobe && !frame_strobe)); // R2

  AST_IDX_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (bit_idx != $past(bit_idx))) |-> $fell(bclk_raw)); // R9

endmodule

// File: tb/sim_audio_clkgen.sv
module sim_audio_clkgen;

  localparam int PM_W = 8;
  localparam int WB_W = 6;
  localparam int SC_W = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            enable = 1'b0;
  logic            clk_half = 1'b0;
  logic            clk_oct = 1'b0;
  logic [PM_W-1:0] clk_pm = '0;
  logic [1:0]      fs_format = 2'd0;
  logic [WB_W-1:0] width_m1 = '0;
  logic [SC_W-1:0] slots_m1 = '0;
  logic            bclk_inv = 1'b0;
  logic            fs_inv = 1'b0;
  logic            bclk;
  logic            fsync;
  logic            cfg_err;
  logic            slot_strobe;
  logic            frame_strobe;
  logic [SC_W-1:0] slot_idx;
  logic [WB_W-1:0] bit_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  audio_clkgen #(.PM_W(PM_W), .WB_W(WB_W), .SC_W(SC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clk_half(clk_half), .clk_oct(clk_oct),
    .clk_pm(clk_pm), .fs_format(fs_format), .width_m1(width_m1), .slots_m1(slots_m1),
    .bclk_inv(bclk_inv), .fs_inv(fs_inv), .bclk(bclk), .fsync(fsync), .cfg_err(cfg_err),
    .slot_strobe(slot_strobe), .frame_strobe(frame_strobe), .slot_idx(slot_idx), .bit_idx(bit_idx)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_fs(input int fmt, input int slot, input int bt, input int w, input int s, input bit finv);
    bit last, first, win, act;
    last  = (slot == s) && (bt == w);
    first = (slot == 0);
    case (fmt)
      0: win = last || (first && bt != w);
      1: win = first;
      2: win = last;
      default: win = first && bt == 0;
    endcase
    act = (fmt != 0);
    return (win ? act : !act) ^ finv;
  endfunction

  task automatic set_cfg(input int fmt, input bit h, input bit o, input int pm, input int w, input int s,
                         input bit bi, input bit fi);
    @(negedge clk);
    enable    = 1'b0;
    fs_format = 2'(fmt);
    clk_half  = h;
    clk_oct   = o;
    clk_pm    = PM_W'(pm);
    width_m1  = WB_W'(w);
    slots_m1  = SC_W'(s);
    bclk_inv  = bi;
    fs_inv    = fi;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_idle(input int fmt, input bit bi, input bit fi);
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    check(bclk == bi, "R13", "idle bclk", int'(bclk), int'(bi));
    check(fsync == ((fmt == 0) ^ fi), "R13", "idle fsync", int'(fsync), int'((fmt == 0) ^ fi));
    check(!slot_strobe && !frame_strobe, "R13", "idle strobes", int'({slot_strobe, frame_strobe}), 0);
  endtask

  // Generic run: checks start timing, period, shape, framing over nfr frames.
  task automatic run_case(input string fsreq, input int fmt, input bit h, input bit o, input int pm,
                          input int w, input int s, input bit bi, input bit fi, input int nfr);
    int d, len, k, last_rise, last_fr, sc, per_bad, fs_bad, fr_bad, nfrm;
    bit raw, prev_raw, prev_ss;
    d   = (h ? 2 : 1) * (o ? 8 : 1) * (pm + 1);
    len = (w + 1) * (s + 1);
    set_cfg(fmt, h, o, pm, w, s, bi, fi);
    enable = 1'b1;
    k = 0;
    while (k < 4 * d + 20) begin
      @(negedge clk);
      k++;
      if (frame_strobe) break;
    end
    check(k == 2 * d + 2, "R10", "first frame strobe delay", k, 2 * d + 2);
    check(slot_idx == 0 && bit_idx == 0, "R10", "start indices", int'({slot_idx, bit_idx}), 0);
    check(cfg_err == 1'b0, "R2", "accepted config no error", int'(cfg_err), 0);
    last_rise = -1; last_fr = 0; sc = 0; per_bad = 0; fs_bad = 0; fr_bad = 0; nfrm = 0;
    prev_raw = bclk ^ bi; prev_ss = 1'b1;
    for (int c = 1; c <= nfr * 2 * d * len; c++) begin
      @(negedge clk);
      raw = bclk ^ bi;
      if (raw && !prev_raw) begin
        if (last_rise >= 0 && (c - last_rise) != 2 * d) per_bad++;
        last_rise = c;
      end
      prev_raw = raw;
      if (fsync != exp_fs(fmt, int'(slot_idx), int'(bit_idx), w, s, fi)) fs_bad++;
      if (slot_strobe && prev_ss) fr_bad++;
      prev_ss = slot_strobe;
      if (slot_strobe) sc++;
      if (frame_strobe) begin
        if ((c - last_fr) != 2 * d * len) fr_bad++;
        if (sc != s + 1) fr_bad++;
        sc = 0;
        last_fr = c;
        nfrm++;
      end
    end
    check(per_bad == 0, "R1", "bclk period errors", per_bad, 0);
    check(fs_bad == 0, fsreq, "fsync shape errors", fs_bad, 0);
    check(fr_bad == 0 && nfrm == nfr, "R9", "frame spacing errors / frames", fr_bad * 1000 + nfrm, nfr);
    check_idle(fmt, bi, fi);
  endtask

  task automatic t_reset;
    check(bclk == 1'b0, "R13", "reset bclk", int'(bclk), 0);
    check(fsync == 1'b1, "R13", "reset fsync (I2S inactive high)", int'(fsync), 1);
    check(cfg_err == 1'b0, "R13", "reset cfg_err", int'(cfg_err), 0);
    check(!slot_strobe && !frame_strobe, "R12", "reset strobes", int'({slot_strobe, frame_strobe}), 0);
  endtask

  task automatic t_err(input string req, input int fmt, input int pm, input int s, input bit expect_err);
    int toggles, strobes;
    bit prev;
    set_cfg(fmt, 1'b0, 1'b0, pm, 3, s, 1'b0, 1'b0);
    enable = 1'b1;
    @(negedge clk);
    check(cfg_err == expect_err, req, "cfg_err after enable", int'(cfg_err), int'(expect_err));
    if (expect_err) begin
      toggles = 0; strobes = 0; prev = bclk;
      repeat (60) begin
        @(negedge clk);
        if (bclk != prev) toggles++;
        prev = bclk;
        if (slot_strobe || frame_strobe) strobes++;
      end
      check(toggles == 0 && strobes == 0, req, "activity under error", toggles + strobes, 0);
      @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      check(cfg_err == 1'b0, "R2", "cfg_err cleared after disable", int'(cfg_err), 0);
    end else begin
      @(negedge clk);
      enable = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic t_live_change;
    int k, last_rise, per_bad, fs_bad;
    bit prev_raw;
    set_cfg(1, 1'b0, 1'b0, 3, 7, 1, 1'b0, 1'b0);
    enable = 1'b1;
    k = 0;
    while (k < 60) begin
      @(negedge clk);
      k++;
      if (frame_strobe) break;
    end
    clk_pm = 8'd20; fs_format = 2'd3; bclk_inv = 1'b1; fs_inv = 1'b1; width_m1 = 6'd2;
    last_rise = -1; per_bad = 0; fs_bad = 0; prev_raw = bclk;
    for (int c = 1; c <= 2 * 8 * 16; c++) begin
      @(negedge clk);
      if (bclk && !prev_raw) begin
        if (last_rise >= 0 && (c - last_rise) != 8) per_bad++;
        last_rise = c;
      end
      prev_raw = bclk;
      if (fsync != exp_fs(1, int'(slot_idx), int'(bit_idx), 7, 1, 1'b0)) fs_bad++;
    end
    check(per_bad == 0 && last_rise > 0, "R11", "period after live change", per_bad, 0);
    check(fs_bad == 0, "R11", "shape after live change", fs_bad, 0);
    check_idle(3, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_case("R5", 1, 1'b0, 1'b0, 31 - 29, 31, 1, 1'b0, 1'b0, 2); // LJ, D=3, ratio 6 accepted
    run_case("R4", 0, 1'b0, 1'b0, 3, 7, 3, 1'b0, 1'b0, 2);
    run_case("R6", 2, 1'b1, 1'b0, 2, 5, 2, 1'b0, 1'b0, 2);
    run_case("R7", 3, 1'b0, 1'b1, 0, 3, 0, 1'b0, 1'b0, 3);
    run_case("R8", 0, 1'b1, 1'b1, 0, 7, 1, 1'b1, 1'b0, 2);
    run_case("R8", 2, 1'b0, 1'b0, 4, 4, 1, 1'b0, 1'b1, 2);
    run_case("R8", 1, 1'b0, 1'b0, 2, 3, 2, 1'b1, 1'b1, 2);
    t_err("R2", 1, 1, 1, 1'b1);
    t_err("R2", 1, 0, 1, 1'b1);
    t_err("R3", 0, 5, 0, 1'b1);
    t_err("R3", 1, 5, 0, 1'b0);
    t_live_change();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule